// File: doc/BRIEF.md
# NaN-Boxing Floating-Point Register File

This block is a floating-point register file whose entries are 64 bits wide and which also holds 32-bit single-precision values. A 32-bit value is kept inside a 64-bit entry: the value sits in the low half and the high half is filled with ones. Seen as a 64-bit number, such an entry is a negative quiet NaN. The file has one write port and two independent read ports. The write port carries a width tag. Each read port carries a width tag and an operation-class input.

A 32-bit write always fills the high half with ones, so every stored narrow value is legally boxed. The source can be a load, a move from an integer register or an arithmetic result. The bit pattern is never converted numerically. On a 32-bit read the operation class decides what happens. A transfer read, which feeds a store or a move to an integer register, passes the low 32 bits through whatever the high half holds. An arithmetic-operand read first checks the box. A badly boxed entry is replaced by the single-precision canonical NaN. Each read port also reports whether the entry it reads is correctly boxed.

The file has no internal sequencing: the only state is the register array. Writes take effect at the rising clock edge and reads are combinational.

Top module: `nanbox_fpr`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every entry to 64'h0, so a 64-bit read of any register returns zero after reset.
- R2: A write with wr_single=1 stores wr_data[31:0] in bits [31:0] of the entry and ones in bits [63:32]. The incoming wr_data[63:32] is discarded and the low bits are not altered.
- R3: A write with wr_single=0 stores all 64 bits of wr_data unchanged. A read with the width tag at 0 returns all 64 bits with no box check, whatever the operation class.
- R4: A 32-bit read (width tag 1) with the operation class at 0 (transfer) returns entry bits [31:0] on data[31:0] and zeros on data[63:32]. It does this even when the entry's upper half is not all ones.
- R5: A 32-bit read with the operation class at 1 (arithmetic) of an entry whose bits [63:32] are all ones returns entry bits [31:0], zero-extended.
- R6: A 32-bit arithmetic read of an entry whose bits [63:32] are not all ones returns 64'h0000_0000_7FC0_0000. This includes an entry that has been reset.
- R7: A port's boxed flag is 1 only on a 32-bit read of an entry whose bits [63:32] are all ones, for either operation class. It is 0 on every 64-bit read.
- R8: Writes take effect at the rising edge. A read of the register being written in the same cycle returns the old contents, and the new contents show from the next cycle.
- R9: Seen through a 64-bit read, every 32-bit write yields a negative quiet NaN: bit 63 set, bits [62:52] all ones and bit 51 set.
- R10: The two read ports are independent. Each one returns its own register with its own width and class at the same time as the other.
- R11: With wr_en low, no entry changes, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 3 | Write register index |
| wr_single | input | 1 | Write width tag: 1 = 32-bit, 0 = 64-bit |
| wr_data | input | 64 | Write data |
| rd_addr_a | input | 3 | Port A register index |
| rd_single_a | input | 1 | Port A width tag: 1 = 32-bit |
| rd_arith_a | input | 1 | Port A class: 1 = arithmetic operand, 0 = transfer |
| rd_data_a | output | 64 | Port A read data |
| rd_boxed_a | output | 1 | Port A: 32-bit read of a correctly boxed entry |
| rd_addr_b | input | 3 | Port B register index |
| rd_single_b | input | 1 | Port B width tag: 1 = 32-bit |
| rd_arith_b | input | 1 | Port B class: 1 = arithmetic operand, 0 = transfer |
| rd_data_b | output | 64 | Port B read data |
| rd_boxed_b | output | 1 | Port B: 32-bit read of a correctly boxed entry |

## Verification
The only internal state is the entry array, so a wrong entry shows up at the ports on the first read after the faulty write, one edge later. A box filled with anything other than ones appears as a clear boxed flag and a canonical NaN on an arithmetic read. A low half that was converted or clipped appears as a mismatch on a transfer read. The upper-half sweep clears one bit at a time and confirms that the substitution turns on for each of the 32 cases and that transfer reads stay untouched.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    localparam int unsigned WIDE_BITS   = 64;
    localparam int unsigned NARROW_BITS = 32;
    localparam logic [NARROW_BITS-1:0] SP_CANON_NAN = 32'h7FC0_0000;

    typedef enum logic {
        OPC_XFER  = 1'b0,
        OPC_ARITH = 1'b1
    } op_class_e;
endpackage

// File: rtl/fpr_store.sv
module fpr_store #(
    parameter int unsigned FLEN   = 64,
    parameter int unsigned NARROW = 32,
    parameter int unsigned NREGS  = 8,
    localparam int unsigned AW    = $clog2(NREGS),
    localparam int unsigned HIGH  = FLEN - NARROW
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic                       wr_single,
    input  logic [FLEN-1:0]            wr_data,
    output logic [NREGS-1:0][FLEN-1:0] regs_q
);
    logic [FLEN-1:0] boxed_val;
    logic            addr_ok;

    assign addr_ok = ({1'b0, wr_addr} < (AW+1)'(NREGS));

    always_comb begin
        if (wr_single) begin
            boxed_val = {{HIGH{1'b1}}, wr_data[NARROW-1:0]};
        end else begin
            boxed_val = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en && addr_ok) begin
            regs_q[wr_addr] <= boxed_val;
        end
    end

    // R2
    narrow_box_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_ok && wr_single) |=>
            (regs_q[$past(wr_addr)] == {{HIGH{1'b1}}, $past(wr_data[NARROW-1:0])}));

    // R3
    wide_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_ok && !wr_single) |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/fpr_read_port.sv
module fpr_read_port
    import fpr_pkg::*;
#(
    parameter int unsigned FLEN   = 64,
    parameter int unsigned NARROW = 32,
    parameter int unsigned NREGS  = 8,
    parameter logic [NARROW-1:0] CANON = SP_CANON_NAN,
    localparam int unsigned AW    = $clog2(NREGS),
    localparam int unsigned HIGH  = FLEN - NARROW
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NREGS-1:0][FLEN-1:0] regs_q,
    input  logic [AW-1:0]              rd_addr,
    input  logic                       rd_single,
    input  op_class_e                  rd_class,
    output logic [FLEN-1:0]            rd_data,
    output logic                       rd_boxed
);
    logic [FLEN-1:0] entry;
    logic            upper_ones;

    always_comb begin
        if ({1'b0, rd_addr} < (AW+1)'(NREGS)) begin
            entry = regs_q[rd_addr];
        end else begin
            entry = '0;
        end
    end

    assign upper_ones = &entry[FLEN-1:NARROW];
    assign rd_boxed   = rd_single & upper_ones;

    always_comb begin
        if (!rd_single) begin
            rd_data = entry;
        end else if ((rd_class == OPC_ARITH) && !upper_ones) begin
            rd_data = {{HIGH{1'b0}}, CANON};
        end else begin
            rd_data = {{HIGH{1'b0}}, entry[NARROW-1:0]};
        end
    end

    // R4
    xfer_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_single && rd_class == OPC_XFER) |->
            (rd_data == {{HIGH{1'b0}}, regs_q[rd_addr][NARROW-1:0]}));

    // R6
    canon_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_single && rd_class == OPC_ARITH && !rd_boxed) |->
            (rd_data == {{HIGH{1'b0}}, CANON}));

    // R7
    wide_no_box_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_single |-> !rd_boxed);

    // R3
    wide_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_single |-> (rd_data == regs_q[rd_addr]));
endmodule

// File: rtl/nanbox_fpr.sv
module nanbox_fpr
    import fpr_pkg::*;
#(
    parameter int unsigned FLEN   = WIDE_BITS,
    parameter int unsigned NARROW = NARROW_BITS,
    parameter int unsigned NREGS  = 8,
    localparam int unsigned AW    = $clog2(NREGS),
    localparam int unsigned NPORT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_single,
    input  logic [FLEN-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr_a,
    input  logic            rd_single_a,
    input  logic            rd_arith_a,
    output logic [FLEN-1:0] rd_data_a,
    output logic            rd_boxed_a,
    input  logic [AW-1:0]   rd_addr_b,
    input  logic            rd_single_b,
    input  logic            rd_arith_b,
    output logic [FLEN-1:0] rd_data_b,
    output logic            rd_boxed_b
);
    logic [NREGS-1:0][FLEN-1:0] regs_q;
    logic [NPORT-1:0][AW-1:0]   p_addr;
    logic [NPORT-1:0]           p_single;
    logic [NPORT-1:0]           p_arith;
    logic [NPORT-1:0][FLEN-1:0] p_data;
    logic [NPORT-1:0]           p_boxed;

    assign p_addr   = {rd_addr_b, rd_addr_a};
    assign p_single = {rd_single_b, rd_single_a};
    assign p_arith  = {rd_arith_b, rd_arith_a};

    assign rd_data_a  = p_data[0];
    assign rd_boxed_a = p_boxed[0];
    assign rd_data_b  = p_data[1];
    assign rd_boxed_b = p_boxed[1];

    fpr_store #(.FLEN(FLEN), .NARROW(NARROW), .NREGS(NREGS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_single (wr_single),
        .wr_data   (wr_data),
        .regs_q    (regs_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fpr_read_port #(.FLEN(FLEN), .NARROW(NARROW), .NREGS(NREGS)) u_rd (
            .clk       (clk),
            .rst       (rst),
            .regs_q    (regs_q),
            .rd_addr   (p_addr[p]),
            .rd_single (p_single[p]),
            .rd_class  (op_class_e'(p_arith[p])),
            .rd_data   (p_data[p]),
            .rd_boxed  (p_boxed[p])
        );
    end
endmodule

// File: tb/tb_nanbox_fpr.sv
module tb_nanbox_fpr;
    localparam logic [63:0] CANON64 = 64'h0000_0000_7FC0_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_single;
    logic [2:0]  wr_addr;
    logic [63:0] wr_data;
    logic [2:0]  rd_addr_a, rd_addr_b;
    logic        rd_single_a, rd_single_b, rd_arith_a, rd_arith_b;
    logic [63:0] rd_data_a, rd_data_b;
    logic        rd_boxed_a, rd_boxed_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [63:0] model [8];

    always #4 clk = ~clk;

    nanbox_fpr dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_single(wr_single), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_single_a(rd_single_a), .rd_arith_a(rd_arith_a),
        .rd_data_a(rd_data_a), .rd_boxed_a(rd_boxed_a),
        .rd_addr_b(rd_addr_b), .rd_single_b(rd_single_b), .rd_arith_b(rd_arith_b),
        .rd_data_b(rd_data_b), .rd_boxed_b(rd_boxed_b)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic single, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_single = single; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model[a] = single ? {32'hFFFF_FFFF, d[31:0]} : d;
    endtask

    task automatic rd_a(input logic [2:0] a, input logic single, input logic arith);
        rd_addr_a = a; rd_single_a = single; rd_arith_a = arith; #1;
    endtask

    task automatic rd_b(input logic [2:0] a, input logic single, input logic arith);
        rd_addr_b = a; rd_single_b = single; rd_arith_b = arith; #1;
    endtask

    function automatic logic [63:0] exp_narrow(input logic [63:0] e, input logic arith);
        if (arith && (e[63:32] != 32'hFFFF_FFFF)) return CANON64;
        return {32'h0, e[31:0]};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_single = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr_a = '0; rd_addr_b = '0;
        rd_single_a = 1'b0; rd_single_b = 1'b0; rd_arith_a = 1'b0; rd_arith_b = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        for (int r = 0; r < 8; r++) model[r] = '0;

        // R1 / R6: reset state
        for (int r = 0; r < 8; r++) begin
            rd_a(3'(r), 1'b0, 1'b0);
            chk("R1 reset wide read", rd_data_a, 64'h0);
            rd_b(3'(r), 1'b1, 1'b1);
            chk("R6 reset arith read", rd_data_b, CANON64);
            chk("R7 reset boxed flag", {63'h0, rd_boxed_b}, 64'h0);
        end

        // R3 / R10 / R7: wide writes, both ports in parallel
        for (int r = 0; r < 8; r++)
            wr(3'(r), 1'b0, {32'hA5A5_0000 | 32'(r), 32'h1234_5600 ^ 32'(r * 17)});
        for (int r = 0; r < 8; r++) begin
            rd_addr_a = 3'(r); rd_single_a = 1'b0; rd_arith_a = 1'b1;
            rd_addr_b = 3'(7 - r); rd_single_b = 1'b0; rd_arith_b = 1'b0; #1;
            chk("R3 wide read port A", rd_data_a, model[r]);
            chk("R10 wide read port B", rd_data_b, model[7 - r]);
            chk("R7 wide boxed flag", {62'h0, rd_boxed_a, rd_boxed_b}, 64'h0);
        end

        // R2 / R5 / R9: narrow writes with garbage upper data
        for (int r = 0; r < 8; r++)
            wr(3'(r), 1'b1, {32'hDEAD_BEE0 | 32'(r), 32'h3F80_0000 + 32'(r * 3)});
        for (int r = 0; r < 8; r++) begin
            rd_a(3'(r), 1'b0, 1'b0);
            chk("R2 narrow box fill", rd_data_a, {32'hFFFF_FFFF, 32'h3F80_0000 + 32'(r * 3)});
            chk("R9 negative quiet NaN", {61'h0, rd_data_a[63], &rd_data_a[62:52], rd_data_a[51]},
                64'h7);
            rd_b(3'(r), 1'b1, 1'b1);
            chk("R5 boxed arith read", rd_data_b, {32'h0, 32'h3F80_0000 + 32'(r * 3)});
            chk("R7 boxed flag set", {63'h0, rd_boxed_b}, 64'h1);
        end

        // R4 / R6 / R7: sweep one cleared bit over the upper half
        for (int k = 0; k < 32; k++) begin
            logic [63:0] v;
            v = {~(32'h1 << k), 32'h4049_0FDB ^ 32'(k)};
            wr(3'd1, 1'b0, v);
            rd_a(3'd1, 1'b1, 1'b1);
            rd_b(3'd1, 1'b1, 1'b0);
            chk("R6 unboxed arith read", rd_data_a, exp_narrow(v, 1'b1));
            chk("R4 transfer read", rd_data_b, exp_narrow(v, 1'b0));
            chk("R7 unboxed flag", {62'h0, rd_boxed_a, rd_boxed_b}, 64'h0);
        end

        // R8: write and read of the same register in one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd5; wr_single = 1'b0; wr_data = 64'hCAFE_F00D_0BAD_BEEF;
        rd_addr_a = 3'd5; rd_single_a = 1'b0; rd_arith_a = 1'b0; #1;
        chk("R8 same-cycle old value", rd_data_a, model[5]);
        @(posedge clk); #1;
        wr_en = 1'b0; model[5] = 64'hCAFE_F00D_0BAD_BEEF;
        chk("R8 new value next cycle", rd_data_a, model[5]);

        // R11: disabled write changes nothing
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 3'd5; wr_single = 1'b1; wr_data = 64'h1111_2222_3333_4444;
        @(posedge clk); #1;
        for (int r = 0; r < 8; r++) begin
            rd_a(3'(r), 1'b0, 1'b0);
            chk("R11 no write when disabled", rd_data_a, model[r]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule